// File: doc/BRIEF.md
# Prioritized Interrupt and Wake Controller

This block gathers three event sources into sticky event flags: an overflow tick from a free-running divider, a level change on any enabled pin of a 4-bit input port, and an underflow tick from a countdown timer. Each flag is qualified by its own interrupt-enable bit and by a global interrupt enable. When the global enable is set and a qualified flag is pending, the controller issues a one-cycle accept pulse. The pulse carries the fixed 11-bit vector of the highest-priority source. Accepting a source clears that source's flag and drops the global enable. Interrupts stay blocked until software re-enables them.

The controller also tracks the low-power mode of the core. In hold mode, a pending flag whose hold-release bit is set ends the hold. If that source may interrupt, it is serviced and the controller returns to hold when the return-from-interrupt strobe arrives. Otherwise the core is told to resume at the next instruction. In stop mode, timer and divider events are ignored. Only a falling edge on a port pin wakes the core. The port pins pass through a two-flop synchronizer before edge detection.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset, flags_o is 0, gie_o is 0, hold_o and stop_o are 0, and ack_o and resume_o are 0.
- R2: A source event sets its flag on the next clock edge, in flags_o bit 0 for the divider, bit 1 for the port and bit 2 for the timer. A flag stays set until it is cleared.
- R3: When gie_o is 1 and some bit of flags_o & irq_en_i is 1 (in run mode, or in hold mode with a release pending), ack_o is 1 for exactly one cycle. vector_o then holds 11'h004 for the divider, 11'h00C for the port or 11'h020 for the timer. vector_o is 0 when ack_o is 0.
- R4: Only one source is accepted per ack_o pulse. The divider wins over the port, and the port wins over the timer.
- R5: On acceptance, the accepted source's flag and gie_o are cleared at the next edge. The other flags are kept.
- R6: gie_set_i or ien_wr_i sets gie_o, and gie_clr_i clears it. If a set and a clear arrive in the same cycle, the clear wins.
- R7: flag_clr_i clears the flags selected by flag_clr_mask_i (same bit order as flags_o). A new event for the same source in the same cycle wins, and its flag stays set.
- R8: hold_req_i in run mode enters hold (hold_o=1). Hold persists until flags_o & hold_en_i is nonzero. Release then either accepts an interrupt (R3) or pulses resume_o for one cycle and returns to run. After an interrupt taken from hold, rti_i returns to hold.
- R9: stop_req_i in run mode enters stop (stop_o=1). In stop, divider and timer events do not set flags. A falling edge on any synchronized port pin leaves stop and pulses resume_o.
- R10: Port pins pass through two synchronizing flops. The port flag is set only by a change on a pin whose bit in port_en_i is 1, three clock edges after the pin changes.
- R11: In run mode, a pending acceptance takes precedence over hold_req_i and stop_req_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_ovf_i | input | 1 | Divider overflow event pulse |
| tmr_udf_i | input | 1 | Timer underflow event pulse |
| port_i | input | 4 | Asynchronous port pins |
| port_en_i | input | 4 | Per-pin change enable |
| irq_en_i | input | 3 | Per-source interrupt enable |
| hold_en_i | input | 3 | Per-source hold-release enable |
| ien_wr_i | input | 1 | Interrupt-enable register write strobe (sets global enable) |
| gie_set_i | input | 1 | Enable-interrupts command |
| gie_clr_i | input | 1 | Disable-interrupts command |
| flag_clr_i | input | 1 | Flag clear command |
| flag_clr_mask_i | input | 3 | Flags cleared by flag_clr_i |
| hold_req_i | input | 1 | Enter hold request |
| stop_req_i | input | 1 | Enter stop request |
| rti_i | input | 1 | Return-from-interrupt strobe |
| ack_o | output | 1 | Interrupt accept pulse |
| vector_o | output | 11 | Vector address of accepted source |
| flags_o | output | 3 | Event flags |
| gie_o | output | 1 | Global interrupt enable |
| hold_o | output | 1 | Hold mode active |
| stop_o | output | 1 | Stop mode active |
| resume_o | output | 1 | Wake without interrupt; continue at next instruction |

## Verification
Two operations can fall in the same cycle and contend for the same flag. A flag-clear command, or the clearing that comes with acceptance, may coincide with a fresh event for the same source. The bench provokes this directly by pulsing a divider event together with a clear of its mask bit. Random runs also pulse events while clears and acceptances are in progress. A cycle model built from the requirements gives the expected outcome, in which the set prevails. The same model judges the collision of a global-enable set with a disable command, and of an acceptance with a hold or stop request.

// File: rtl/iwc_pkg.sv
package iwc_pkg;
  localparam int N_SRC    = 3;
  localparam int VEC_W    = 11;
  localparam int SRC_DIV  = 0;
  localparam int SRC_PORT = 1;
  localparam int SRC_TMR  = 2;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_HOLD = 2'd1,
    MODE_STOP = 2'd2
  } mode_e;

  // fixed, unevenly spaced vector table
  function automatic logic [VEC_W-1:0] src_vector(input int idx);
    case (idx)
      SRC_DIV:  return 11'h004;
      SRC_PORT: return 11'h00C;
      SRC_TMR:  return 11'h020;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/iwc_port_sync.sv
module iwc_port_sync #(
  parameter int          W       = 4,
  parameter logic [W-1:0] IDLE   = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] pin_en_i,
  output logic         chg_o,
  output logic         fall_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= IDLE;
      s2_q   <= IDLE;
      prev_q <= IDLE;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign chg_o  = |((s2_q ^ prev_q) & pin_en_i);
  assign fall_o = |(prev_q & ~s2_q);
endmodule

// File: rtl/iwc_flags.sv
module iwc_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;

  // hardware set prevails over any clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/iwc_prio.sv
module iwc_prio
  import iwc_pkg::*;
#(
  parameter int N = N_SRC
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [VEC_W-1:0] vec_o
);
  // lowest index wins
  always_comb begin
    grant_o = '0;
    vec_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        vec_o      = src_vector(i);
      end
    end
  end
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import iwc_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_ovf_i,
  input  logic              tmr_udf_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [PORT_W-1:0] port_en_i,
  input  logic [N_SRC-1:0]  irq_en_i,
  input  logic [N_SRC-1:0]  hold_en_i,
  input  logic              ien_wr_i,
  input  logic              gie_set_i,
  input  logic              gie_clr_i,
  input  logic              flag_clr_i,
  input  logic [N_SRC-1:0]  flag_clr_mask_i,
  input  logic              hold_req_i,
  input  logic              stop_req_i,
  input  logic              rti_i,
  output logic              ack_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic [N_SRC-1:0]  flags_o,
  output logic              gie_o,
  output logic              hold_o,
  output logic              stop_o,
  output logic              resume_o
);
  mode_e              mode_q, mode_d;
  logic               gie_q, gie_d;
  logic               ret_hold_q, ret_hold_d;
  logic               port_chg, port_fall;
  logic [N_SRC-1:0]   flags, req, grant, set_vec, clr_vec;
  logic [VEC_W-1:0]   pvec;
  logic               wake, take;

  iwc_port_sync #(.W(PORT_W)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (port_i),
    .pin_en_i (port_en_i),
    .chg_o    (port_chg),
    .fall_o   (port_fall)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_DIV]  = div_ovf_i & (mode_q != MODE_STOP);
    set_vec[SRC_PORT] = port_chg;
    set_vec[SRC_TMR]  = tmr_udf_i & (mode_q != MODE_STOP);
    clr_vec           = (flag_clr_i ? flag_clr_mask_i : '0) | (take ? grant : '0);
  end

  iwc_flags #(.N(N_SRC)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .flags_o (flags)
  );

  assign req = flags & irq_en_i;

  iwc_prio #(.N(N_SRC)) u_prio (
    .req_i   (req),
    .grant_o (grant),
    .vec_o   (pvec)
  );

  assign wake = |(flags & hold_en_i);
  assign take = gie_q & (|req) &
                ((mode_q == MODE_RUN) || ((mode_q == MODE_HOLD) && wake));

  always_comb begin
    mode_d     = mode_q;
    ret_hold_d = ret_hold_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (take) begin
          mode_d = MODE_RUN;
        end else if (rti_i && ret_hold_q) begin
          mode_d     = MODE_HOLD;
          ret_hold_d = 1'b0;
        end else if (stop_req_i) begin
          mode_d = MODE_STOP;
        end else if (hold_req_i) begin
          mode_d = MODE_HOLD;
        end
      end
      MODE_HOLD: begin
        if (take) begin
          mode_d     = MODE_RUN;
          ret_hold_d = 1'b1;
        end else if (wake) begin
          mode_d = MODE_RUN;
        end
      end
      MODE_STOP: begin
        if (port_fall) mode_d = MODE_RUN;
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_comb begin
    gie_d = gie_q;
    if (take || gie_clr_i)          gie_d = 1'b0;
    else if (gie_set_i || ien_wr_i) gie_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_RUN;
      gie_q      <= 1'b0;
      ret_hold_q <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      gie_q      <= gie_d;
      ret_hold_q <= ret_hold_d;
    end
  end

  assign ack_o    = take;
  assign vector_o = take ? pvec : '0;
  assign flags_o  = flags;
  assign gie_o    = gie_q;
  assign hold_o   = (mode_q == MODE_HOLD);
  assign stop_o   = (mode_q == MODE_STOP);
  assign resume_o = ((mode_q == MODE_HOLD) && wake && !take) ||
                    ((mode_q == MODE_STOP) && port_fall);
endmodule

// File: rtl/irq_wake_ctrl_chk.sv
module irq_wake_ctrl_chk
  import iwc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              div_ovf_i,
  input logic [N_SRC-1:0]  irq_en_i,
  input logic [N_SRC-1:0]  hold_en_i,
  input logic              ack_o,
  input logic [VEC_W-1:0]  vector_o,
  input logic [N_SRC-1:0]  flags_o,
  input logic              gie_o,
  input logic              hold_o,
  input logic              stop_o,
  input logic              resume_o
);
  assert_ack_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  assert_vec_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (vector_o == 11'h004 || vector_o == 11'h00C || vector_o == 11'h020));

  assert_div_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && flags_o[0] && irq_en_i[0]) |-> vector_o == 11'h004);

  assert_gie_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !gie_o);

  assert_div_flag_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && vector_o == 11'h004 && !div_ovf_i) |=> !flags_o[0]);

  assert_hold_stays_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !(|(flags_o & hold_en_i))) |=> hold_o);

  assert_resume_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> !ack_o);

  assert_stop_div_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && !flags_o[0]) |=> !flags_o[0]);

  assert_mode_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hold_o, stop_o}));
endmodule

bind irq_wake_ctrl irq_wake_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .div_ovf_i (div_ovf_i),
  .irq_en_i  (irq_en_i),
  .hold_en_i (hold_en_i),
  .ack_o     (ack_o),
  .vector_o  (vector_o),
  .flags_o   (flags_o),
  .gie_o     (gie_o),
  .hold_o    (hold_o),
  .stop_o    (stop_o),
  .resume_o  (resume_o)
);

// File: tb/irq_wake_ctrl_tb.sv
module irq_wake_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_ovf = 0, tmr_udf = 0;
  logic [3:0]  port = 4'hF, port_en = 4'hF;
  logic [2:0]  irq_en = 0, hold_en = 0, clr_mask = 0;
  logic        ien_wr = 0, gie_set = 0, gie_clr = 0, flag_clr = 0;
  logic        hold_req = 0, stop_req = 0, rti = 0;
  logic        ack;
  logic [10:0] vector;
  logic [2:0]  flags;
  logic        gie, hold, stop, resume;

  int checks = 0, errors = 0;
  logic [10:0] last_vec;

  // reference model state (0 run, 1 hold, 2 stop)
  logic [2:0] m_flags;
  logic       m_gie, m_ret;
  int         m_mode;
  logic [3:0] m_s1, m_s2, m_prev;

  always #5 clk = ~clk;

  irq_wake_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .div_ovf_i(div_ovf), .tmr_udf_i(tmr_udf),
    .port_i(port), .port_en_i(port_en), .irq_en_i(irq_en), .hold_en_i(hold_en),
    .ien_wr_i(ien_wr), .gie_set_i(gie_set), .gie_clr_i(gie_clr),
    .flag_clr_i(flag_clr), .flag_clr_mask_i(clr_mask), .hold_req_i(hold_req),
    .stop_req_i(stop_req), .rti_i(rti), .ack_o(ack), .vector_o(vector),
    .flags_o(flags), .gie_o(gie), .hold_o(hold), .stop_o(stop), .resume_o(resume)
  );

  function automatic logic [10:0] vec_of(input logic [2:0] r);
    if (r[0]) return 11'h004;
    if (r[1]) return 11'h00C;
    if (r[2]) return 11'h020;
    return 11'h000;
  endfunction

  function automatic logic [2:0] grant_of(input logic [2:0] r);
    if (r[0]) return 3'b001;
    if (r[1]) return 3'b010;
    if (r[2]) return 3'b100;
    return 3'b000;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_flags = 0; m_gie = 0; m_ret = 0; m_mode = 0;
    m_s1 = 4'hF; m_s2 = 4'hF; m_prev = 4'hF;
  endtask

  // inputs are stable here; compare, then advance model across the edge
  task automatic step();
    logic [2:0] req, set, clr;
    logic       wake, fall, chg, take, res;
    logic [10:0] ev;
    #2;
    req  = m_flags & irq_en;
    wake = |(m_flags & hold_en);
    fall = |(m_prev & ~m_s2);
    chg  = |((m_s2 ^ m_prev) & port_en);
    take = m_gie && (|req) && (m_mode == 0 || (m_mode == 1 && wake));
    res  = (m_mode == 1 && wake && !take) || (m_mode == 2 && fall);
    ev   = take ? vec_of(req) : 11'h000;
    chk(ack == take && vector == ev, "R3 accept/vector", {ack, vector}, {take, ev});
    chk(flags == m_flags, "R2 flags", flags, m_flags);
    chk(gie == m_gie, "R6 gie", gie, m_gie);
    chk(hold == (m_mode == 1) && stop == (m_mode == 2), "R8 mode",
        {hold, stop}, {m_mode == 1, m_mode == 2});
    chk(resume == res, "R9 resume", resume, res);
    if (ack) last_vec = vector;
    set = {tmr_udf && m_mode != 2, chg, div_ovf && m_mode != 2};
    clr = (flag_clr ? clr_mask : 3'b0) | (take ? grant_of(req) : 3'b0);
    m_flags = (m_flags & ~clr) | set;
    if (take || gie_clr) m_gie = 0;
    else if (gie_set || ien_wr) m_gie = 1;
    case (m_mode)
      0: if (take) m_mode = 0;
         else if (rti && m_ret) begin m_mode = 1; m_ret = 0; end
         else if (stop_req) m_mode = 2;
         else if (hold_req) m_mode = 1;
      1: if (take) begin m_mode = 0; m_ret = 1; end
         else if (wake) m_mode = 0;
      default: if (fall) m_mode = 0;
    endcase
    m_prev = m_s2; m_s2 = m_s1; m_s1 = port;
    @(negedge clk);
  endtask

  task automatic idle();
    div_ovf = 0; tmr_udf = 0; ien_wr = 0; gie_set = 0; gie_clr = 0;
    flag_clr = 0; hold_req = 0; stop_req = 0; rti = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin step(); idle(); end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(flags == 0 && gie == 0 && !hold && !stop && !ack && !resume,
        "R1 reset", {flags, gie, hold, stop, ack, resume}, 0);
    rst_n = 1'b1;
    run(2);

    // R4 priority: all three pending, released one by one
    irq_en = 3'b111;
    div_ovf = 1; tmr_udf = 1; port = 4'hE; step(); idle();
    run(4);
    chk(flags == 3'b111, "R2 all set", flags, 3'b111);
    gie_set = 1; step(); idle(); step();
    chk(last_vec == 11'h004, "R4 first divider", last_vec, 11'h004);
    chk(flags == 3'b110, "R5 only div cleared", flags, 3'b110);
    ien_wr = 1; step(); idle(); step();
    chk(last_vec == 11'h00C, "R4 second port", last_vec, 11'h00C);
    gie_set = 1; step(); idle(); step();
    chk(last_vec == 11'h020, "R4 third timer", last_vec, 11'h020);
    chk(gie == 0, "R5 gie dropped", gie, 0);

    // R6 set and clear together
    gie_set = 1; gie_clr = 1; step(); idle(); step();
    chk(gie == 0, "R6 clear wins", gie, 0);

    // R7 clear vs same-cycle set
    irq_en = 0;
    div_ovf = 1; step(); idle();
    flag_clr = 1; clr_mask = 3'b001; div_ovf = 1; step(); idle(); step();
    chk(flags[0] == 1, "R7 set wins", flags[0], 1);
    flag_clr = 1; step(); idle(); step();
    chk(flags[0] == 0, "R7 cleared", flags[0], 0);

    // R10 disabled pin change is ignored
    port_en = 4'b0001; port = 4'hC; run(5);
    chk(flags[1] == 0, "R10 masked pin", flags[1], 0);
    port = 4'hD; run(2);
    chk(flags[1] == 0, "R10 two-flop delay", flags[1], 0);
    step();
    chk(flags[1] == 1, "R10 enabled pin", flags[1], 1);
    flag_clr = 1; clr_mask = 3'b111; step(); idle();

    // R8 hold without interrupt, then with interrupt and return
    hold_en = 3'b001; hold_req = 1; step(); idle();
    tmr_udf = 1; run(3);
    chk(hold == 1, "R8 hold kept", hold, 1);
    div_ovf = 1; step(); idle(); step();
    chk(hold == 0 && resume == 0, "R8 released", {hold, resume}, 0);
    flag_clr = 1; clr_mask = 3'b111; step(); idle();
    irq_en = 3'b001; gie_set = 1; hold_req = 1; step(); idle();
    div_ovf = 1; run(3);
    chk(last_vec == 11'h004 && hold == 0, "R8 serviced", last_vec, 11'h004);
    rti = 1; step(); idle(); step();
    chk(hold == 1, "R8 back to hold", hold, 1);
    hold_en = 0; irq_en = 0; run(2);

    // R11 accept beats hold request
    irq_en = 3'b100; hold_en = 3'b100; tmr_udf = 1; step(); idle();
    ien_wr = 1; step(); idle();
    hold_req = 1; step(); idle(); step();
    chk(hold == 0 && last_vec == 11'h020, "R11 accept first", hold, 0);

    // R9 stop
    port_en = 4'hF; stop_req = 1; step(); idle();
    div_ovf = 1; tmr_udf = 1; run(3);
    chk(stop == 1 && flags[0] == 0, "R9 events ignored", {stop, flags[0]}, 2'b10);
    port = 4'h5; run(4);
    chk(stop == 0, "R9 woke on fall", stop, 0);

    // random phase
    for (int blk = 0; blk < 60; blk++) begin
      irq_en = $urandom; hold_en = $urandom; port_en = $urandom;
      for (int c = 0; c < 64; c++) begin
        div_ovf  = ($urandom % 8) == 0;
        tmr_udf  = ($urandom % 8) == 0;
        if (($urandom % 10) == 0) port = port ^ (4'h1 << ($urandom % 4));
        gie_set  = ($urandom % 6) == 0;
        gie_clr  = ($urandom % 20) == 0;
        ien_wr   = ($urandom % 30) == 0;
        flag_clr = ($urandom % 12) == 0;
        clr_mask = $urandom;
        hold_req = ($urandom % 20) == 0;
        stop_req = ($urandom % 50) == 0;
        rti      = ($urandom % 10) == 0;
        step();
      end
    end
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule